// File: doc/BRIEF.md
# Two-Stream Overlay Pixel Compositor

This block merges a primary graphics stream with a secondary video stream, one pixel per clock. For each incoming pixel pair it decides whether the current screen position falls inside the secondary window. Outside the window the primary pixel passes through untouched. Inside the window one of several compose rules picks or mixes the two pixels: opaque overlay in either direction, an eight-step dissolve, a two-coefficient fade, or color keying on either stream.

Keying has two sources. In range mode, the keyed stream's RGB value is compared against per-channel low and upper bounds at a chosen precision. In flag mode, a one-bit key flag that travels with the keyed pixel decides alone. The control inputs are static settings that the surrounding logic holds steady while pixels are in flight. The datapath has two register stages, and a valid bit travels alongside the pixel.

Pixels are packed as {R, G, B}, with R in the most significant CH_W bits and B in the least significant.

Top module: `ovl_compositor`

## Requirements
- R1: `out_valid` is low after reset. A pixel accepted with `in_valid` high appears on `out_pix` with `out_valid` high exactly two clocks later. `out_valid` is low in the clock between.
- R2: A pixel is inside the window when pos_x+1 is between `cfg_win_x` and `cfg_win_x`+`cfg_win_w`, both ends included, and pos_y+1 is at least `cfg_win_y` and below `cfg_win_y`+`cfg_win_h`. Outside the window the output is the primary pixel, whatever the mode.
- R3: Inside the window, mode code 0 outputs the secondary pixel. Reserved codes 4 and 7 behave the same way.
- R4: Inside the window, mode code 1 outputs the primary pixel.
- R5: Mode code 2 (dissolve) outputs, per channel, floor((P*Kp + S*(8-Kp))/8). `cfg_ks` has no effect in this mode.
- R6: Mode code 3 (fade) outputs, per channel, floor((P*Kp + S*Ks)/8). The settings must satisfy Kp+Ks <= 8.
- R7: Mode code 5 keys on the primary pixel. On a key match the output is the secondary pixel; otherwise it is the primary pixel.
- R8: Mode code 6 keys on the secondary pixel. On a key match the output is the primary pixel; otherwise it is the secondary pixel.
- R9: With `cfg_key_range` = 1, precision code n keeps the top n+1 bits of each channel: code 0 keeps bit 7 only, code 7 keeps all eight bits. A match needs every masked channel to lie between its masked low and upper bound, both ends included.
- R10: With `cfg_key_range` = 0, the keyed stream's key flag bit alone decides the match (1 = match), and the bounds have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input pixel pair is valid |
| pri_pix | input | 24 | Primary pixel {R,G,B} |
| pri_kflag | input | 1 | Primary key flag bit |
| sec_pix | input | 24 | Secondary pixel {R,G,B} |
| sec_kflag | input | 1 | Secondary key flag bit |
| pos_x | input | 11 | Screen column |
| pos_y | input | 11 | Screen line |
| cfg_mode | input | 3 | Compose mode code |
| cfg_kp | input | 3 | Primary blend coefficient |
| cfg_ks | input | 3 | Secondary blend coefficient |
| cfg_key_prec | input | 3 | Key comparison precision code |
| cfg_key_range | input | 1 | 1 = range keying, 0 = flag keying |
| cfg_key_lo | input | 24 | Low key bounds {R,G,B} |
| cfg_key_hi | input | 24 | Upper key bounds {R,G,B} |
| cfg_win_x | input | 11 | Window start column plus one |
| cfg_win_y | input | 11 | Window start line plus one |
| cfg_win_w | input | 11 | Window width minus one |
| cfg_win_h | input | 11 | Window height in lines |
| out_valid | output | 1 | Output pixel is valid |
| out_pix | output | 24 | Composited pixel {R,G,B} |

## Verification
The assertions assume that the control inputs do not change while a pixel sits in either pipeline stage. They also assume that any pixel entering in fade mode carries coefficients whose sum does not exceed eight. The bench meets both conditions. It sends one pixel at a time and alters settings only after the previous pixel has left the output register. It also drives fade mode only with legal coefficient pairs, including the boundary sum of exactly eight.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   typedef enum logic [2:0] {
      OVL_SEC_TOP  = 3'd0,
      OVL_PRI_TOP  = 3'd1,
      OVL_DISSOLVE = 3'd2,
      OVL_FADE     = 3'd3,
      OVL_RSV4     = 3'd4,
      OVL_KEY_PRI  = 3'd5,
      OVL_KEY_SEC  = 3'd6,
      OVL_RSV7     = 3'd7
   } ovl_mode_e;

   localparam int OVL_LANES = 3;
endpackage

// File: rtl/ovl_window_hit.sv
module ovl_window_hit #(
   parameter int COORD_W = 11
) (
   input  logic [COORD_W-1:0] pos_x,
   input  logic [COORD_W-1:0] pos_y,
   input  logic [COORD_W-1:0] win_x,
   input  logic [COORD_W-1:0] win_y,
   input  logic [COORD_W-1:0] win_w,
   input  logic [COORD_W-1:0] win_h,
   output logic               hit
);
   localparam int EW = COORD_W + 2;

   logic [EW-1:0] xp1, yp1, x_end, y_end;
   logic          in_x, in_y;

   // registers hold coordinate+1, so compare position+1 to avoid underflow
   always_comb begin
      xp1   = EW'(pos_x) + EW'(1);
      yp1   = EW'(pos_y) + EW'(1);
      x_end = EW'(win_x) + EW'(win_w);
      y_end = EW'(win_y) + EW'(win_h);
      in_x  = (xp1 >= EW'(win_x)) && (xp1 <= x_end);
      in_y  = (yp1 >= EW'(win_y)) && (yp1 <  y_end);
      hit   = in_x && in_y;
   end
endmodule

// File: rtl/ovl_key_match.sv
module ovl_key_match #(
   parameter int CH_W   = 8,
   parameter int LANES  = 3,
   parameter int PREC_W = 3
) (
   input  logic [LANES*CH_W-1:0] pix,
   input  logic                  kflag,
   input  logic                  range_en,
   input  logic [PREC_W-1:0]     prec,
   input  logic [LANES*CH_W-1:0] lo,
   input  logic [LANES*CH_W-1:0] hi,
   output logic                  match
);
   logic [CH_W-1:0]  mask;
   logic [LANES-1:0] lane_ok;

   // keep the top prec+1 bits of each channel
   always_comb begin
      for (int i = 0; i < CH_W; i++)
         mask[CH_W-1-i] = (i <= int'(prec));
   end

   for (genvar c = 0; c < LANES; c++) begin : g_lane
      logic [CH_W-1:0] v_m, lo_m, hi_m;
      assign v_m  = pix[c*CH_W +: CH_W] & mask;
      assign lo_m = lo[c*CH_W +: CH_W]  & mask;
      assign hi_m = hi[c*CH_W +: CH_W]  & mask;
      assign lane_ok[c] = (v_m >= lo_m) && (v_m <= hi_m);
   end

   assign match = range_en ? (&lane_ok) : kflag;
endmodule

// File: rtl/ovl_blend_lane.sv
module ovl_blend_lane #(
   parameter int CH_W   = 8,
   parameter int FRAC_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [CH_W-1:0]   p,
   input  logic [CH_W-1:0]   s,
   input  logic [FRAC_W-1:0] kp,
   input  logic [FRAC_W-1:0] ks,
   input  logic              fade,
   output logic [CH_W-1:0]   q
);
   localparam int WW    = FRAC_W + 1;
   localparam int SUM_W = CH_W + FRAC_W + 2;
   localparam int ONE   = 1 << FRAC_W;

   logic [WW-1:0]    wp, ws;
   logic [SUM_W-1:0] sum;

   always_comb begin
      wp  = {1'b0, kp};
      ws  = fade ? {1'b0, ks} : (WW'(ONE) - {1'b0, kp});
      sum = SUM_W'(p) * SUM_W'(wp) + SUM_W'(s) * SUM_W'(ws);
      q   = sum[FRAC_W +: CH_W];   // divide by 2^FRAC_W, truncating
   end

   // a dissolve is a weighted mean: result stays between the two inputs
   assert_dissolve_bounded_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !fade) |-> ((q >= ((p < s) ? p : s)) && (q <= ((p > s) ? p : s))));
endmodule

// File: rtl/ovl_compositor.sv
module ovl_compositor
   import ovl_pkg::*;
#(
   parameter int CH_W    = 8,
   parameter int COORD_W = 11,
   parameter int FRAC_W  = 3,
   parameter int PREC_W  = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [3*CH_W-1:0]    pri_pix,
   input  logic                 pri_kflag,
   input  logic [3*CH_W-1:0]    sec_pix,
   input  logic                 sec_kflag,
   input  logic [COORD_W-1:0]   pos_x,
   input  logic [COORD_W-1:0]   pos_y,
   input  logic [2:0]           cfg_mode,
   input  logic [FRAC_W-1:0]    cfg_kp,
   input  logic [FRAC_W-1:0]    cfg_ks,
   input  logic [PREC_W-1:0]    cfg_key_prec,
   input  logic                 cfg_key_range,
   input  logic [3*CH_W-1:0]    cfg_key_lo,
   input  logic [3*CH_W-1:0]    cfg_key_hi,
   input  logic [COORD_W-1:0]   cfg_win_x,
   input  logic [COORD_W-1:0]   cfg_win_y,
   input  logic [COORD_W-1:0]   cfg_win_w,
   input  logic [COORD_W-1:0]   cfg_win_h,
   output logic                 out_valid,
   output logic [3*CH_W-1:0]    out_pix
);
   localparam int PIX_W = OVL_LANES * CH_W;
   localparam int ONE   = 1 << FRAC_W;

   if (CH_W < 4) begin : g_bad_ch
      $error("ovl_compositor: CH_W must be at least 4");
   end
   if ((1 << PREC_W) > CH_W) begin : g_bad_prec
      $error("ovl_compositor: precision code range exceeds channel width");
   end
   if (COORD_W < 2) begin : g_bad_coord
      $error("ovl_compositor: COORD_W too small");
   end

   ovl_mode_e mode;
   assign mode = ovl_mode_e'(cfg_mode);

   // ---------------- stage 1: window test and key match ----------------
   logic             win_hit, key_hit, key_on_sec;
   logic [PIX_W-1:0] key_src;
   logic             key_flag;

   assign key_on_sec = (mode == OVL_KEY_SEC);
   assign key_src    = key_on_sec ? sec_pix   : pri_pix;
   assign key_flag   = key_on_sec ? sec_kflag : pri_kflag;

   ovl_window_hit #(.COORD_W(COORD_W)) u_win (
      .pos_x (pos_x),     .pos_y (pos_y),
      .win_x (cfg_win_x), .win_y (cfg_win_y),
      .win_w (cfg_win_w), .win_h (cfg_win_h),
      .hit   (win_hit)
   );

   ovl_key_match #(.CH_W(CH_W), .LANES(OVL_LANES), .PREC_W(PREC_W)) u_key (
      .pix      (key_src),
      .kflag    (key_flag),
      .range_en (cfg_key_range),
      .prec     (cfg_key_prec),
      .lo       (cfg_key_lo),
      .hi       (cfg_key_hi),
      .match    (key_hit)
   );

   logic             s1_valid, s1_hit, s1_match;
   logic [PIX_W-1:0] s1_pri, s1_sec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_hit   <= 1'b0;
         s1_match <= 1'b0;
         s1_pri   <= '0;
         s1_sec   <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_hit   <= win_hit;
            s1_match <= key_hit;
            s1_pri   <= pri_pix;
            s1_sec   <= sec_pix;
         end
      end
   end

   // ---------------- stage 2: blend and compose ----------------
   logic [PIX_W-1:0] blend_pix, comp_pix;
   logic             is_fade;
   assign is_fade = (mode == OVL_FADE);

   for (genvar c = 0; c < OVL_LANES; c++) begin : g_blend
      ovl_blend_lane #(.CH_W(CH_W), .FRAC_W(FRAC_W)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .chk_en (s1_valid && (mode == OVL_DISSOLVE)),
         .p      (s1_pri[c*CH_W +: CH_W]),
         .s      (s1_sec[c*CH_W +: CH_W]),
         .kp     (cfg_kp),
         .ks     (cfg_ks),
         .fade   (is_fade),
         .q      (blend_pix[c*CH_W +: CH_W])
      );
   end

   always_comb begin
      unique case (mode)
         OVL_PRI_TOP:             comp_pix = s1_pri;
         OVL_DISSOLVE, OVL_FADE:  comp_pix = blend_pix;
         OVL_KEY_PRI:             comp_pix = s1_match ? s1_sec : s1_pri;
         OVL_KEY_SEC:             comp_pix = s1_match ? s1_pri : s1_sec;
         default:                 comp_pix = s1_sec;   // 0 and reserved 4, 7
      endcase
      if (!s1_hit) comp_pix = s1_pri;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_pix <= comp_pix;
      end
   end

   // ---------------- assertions ----------------
   assert_latency_two_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);

   assert_no_spurious_valid_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##1 !out_valid);

   assert_outside_passes_primary_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !s1_hit) |=> (out_pix == $past(s1_pri)));

   assert_secondary_opaque_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && (mode inside {OVL_SEC_TOP, OVL_RSV4, OVL_RSV7}))
      |=> (out_pix == $past(s1_sec)));

   assert_primary_opaque_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && s1_hit && (mode == OVL_PRI_TOP)) |=> (out_pix == $past(s1_pri)));

   assert_fade_coef_sum_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (mode == OVL_FADE)) |-> ((32'(cfg_kp) + 32'(cfg_ks)) <= 32'(ONE)));
endmodule

// File: tb/ovl_compositor_tb.sv
module ovl_compositor_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [23:0] pri_pix = '0, sec_pix = '0;
   logic        pri_kflag = 1'b0, sec_kflag = 1'b0;
   logic [10:0] pos_x = '0, pos_y = '0;
   logic [2:0]  cfg_mode = '0, cfg_kp = '0, cfg_ks = '0, cfg_key_prec = 3'd7;
   logic        cfg_key_range = 1'b1;
   logic [23:0] cfg_key_lo = '0, cfg_key_hi = '0;
   logic [10:0] cfg_win_x = '0, cfg_win_y = '0, cfg_win_w = '0, cfg_win_h = '0;
   logic        out_valid;
   logic [23:0] out_pix;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   ovl_compositor u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .pri_pix(pri_pix), .pri_kflag(pri_kflag),
      .sec_pix(sec_pix), .sec_kflag(sec_kflag),
      .pos_x(pos_x), .pos_y(pos_y),
      .cfg_mode(cfg_mode), .cfg_kp(cfg_kp), .cfg_ks(cfg_ks),
      .cfg_key_prec(cfg_key_prec), .cfg_key_range(cfg_key_range),
      .cfg_key_lo(cfg_key_lo), .cfg_key_hi(cfg_key_hi),
      .cfg_win_x(cfg_win_x), .cfg_win_y(cfg_win_y),
      .cfg_win_w(cfg_win_w), .cfg_win_h(cfg_win_h),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   task automatic chk(string req, logic [23:0] got, logic [23:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %06h expected %06h", req, got, exp);
      end
   endtask

   // expected output, built from the requirement text
   function automatic logic [23:0] model(logic [23:0] p, logic pk,
                                         logic [23:0] s, logic sk,
                                         int x, int y);
      logic [23:0] r;
      logic [7:0]  m;
      bit          hit, match, all_in;
      int          kp, ks;
      hit = (x + 1 >= int'(cfg_win_x)) && (x + 1 <= int'(cfg_win_x) + int'(cfg_win_w)) &&
            (y + 1 >= int'(cfg_win_y)) && (y + 1 <  int'(cfg_win_y) + int'(cfg_win_h));
      if (!hit) return p;
      kp = int'(cfg_kp);
      ks = (cfg_mode == 3'd3) ? int'(cfg_ks) : 8 - kp;
      m  = 8'hFF << (7 - int'(cfg_key_prec));
      all_in = 1'b1;
      for (int c = 0; c < 3; c++) begin
         logic [7:0] v;
         v = (cfg_mode == 3'd6) ? s[c*8 +: 8] : p[c*8 +: 8];
         if (!(((v & m) >= (cfg_key_lo[c*8 +: 8] & m)) &&
               ((v & m) <= (cfg_key_hi[c*8 +: 8] & m)))) all_in = 1'b0;
         r[c*8 +: 8] = 8'((int'(p[c*8 +: 8]) * kp + int'(s[c*8 +: 8]) * ks) / 8);
      end
      match = cfg_key_range ? all_in : ((cfg_mode == 3'd6) ? sk : pk);
      case (cfg_mode)
         3'd1:       return p;
         3'd2, 3'd3: return r;
         3'd5:       return match ? s : p;
         3'd6:       return match ? p : s;
         default:    return s;
      endcase
   endfunction

   task automatic apply(string req, logic [23:0] p, logic pk,
                        logic [23:0] s, logic sk, int x, int y);
      logic [23:0] e;
      e = model(p, pk, s, sk, x, y);
      @(negedge clk);
      pri_pix = p; pri_kflag = pk; sec_pix = s; sec_kflag = sk;
      pos_x = 11'(x); pos_y = 11'(y); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1 valid low mid-pipe", {23'd0, out_valid}, 24'd0);
      @(negedge clk);
      chk("R1 valid after two clocks", {23'd0, out_valid}, 24'd1);
      chk(req, out_pix, e);
   endtask

   task automatic set_window(int x0, int w, int y0, int h);
      @(negedge clk);
      cfg_win_x = 11'(x0 + 1); cfg_win_w = 11'(w - 1);
      cfg_win_y = 11'(y0 + 1); cfg_win_h = 11'(h);
   endtask

   task automatic t_reset;
      chk("R1 reset valid", {23'd0, out_valid}, 24'd0);
      chk("R1 reset pixel", out_pix, 24'd0);
   endtask

   task automatic t_window;
      set_window(10, 5, 5, 3);   // columns 10..14, lines 5..7
      cfg_mode = 3'd0;
      apply("R2 left of window",  24'h112233, 0, 24'hAABBCC, 0,  9, 6);
      apply("R2 first column",    24'h112233, 0, 24'hAABBCC, 0, 10, 6);
      apply("R2 last column",     24'h112233, 0, 24'hAABBCC, 0, 14, 6);
      apply("R2 right of window", 24'h112233, 0, 24'hAABBCC, 0, 15, 6);
      apply("R2 above window",    24'h112233, 0, 24'hAABBCC, 0, 12, 4);
      apply("R2 last line",       24'h112233, 0, 24'hAABBCC, 0, 12, 7);
      apply("R2 below window",    24'h112233, 0, 24'hAABBCC, 0, 12, 8);
      cfg_mode = 3'd2; cfg_kp = 3'd3;
      apply("R2 outside ignores dissolve", 24'h112233, 0, 24'hAABBCC, 0, 30, 6);
   endtask

   task automatic t_opaque;
      set_window(0, 64, 0, 64);
      cfg_mode = 3'd0; apply("R3 mode 0",        24'h102030, 0, 24'hF0E0D0, 0, 3, 3);
      cfg_mode = 3'd4; apply("R3 reserved 4",    24'h102030, 0, 24'hF0E0D0, 0, 3, 3);
      cfg_mode = 3'd7; apply("R3 reserved 7",    24'h102030, 0, 24'hF0E0D0, 0, 3, 3);
      cfg_mode = 3'd1; apply("R4 primary on top", 24'h102030, 0, 24'hF0E0D0, 0, 3, 3);
   endtask

   task automatic t_dissolve;
      cfg_mode = 3'd2;
      cfg_kp = 3'd3; cfg_ks = 3'd0; apply("R5 dissolve kp3",     24'h804020, 0, 24'h20FF07, 0, 1, 1);
      cfg_ks = 3'd7;                apply("R5 dissolve ks unused", 24'h804020, 0, 24'h20FF07, 0, 1, 1);
      cfg_kp = 3'd0;                apply("R5 dissolve kp0",     24'h804020, 0, 24'h20FF07, 0, 1, 1);
      cfg_kp = 3'd7;                apply("R5 dissolve kp7",     24'hFFFFFF, 0, 24'h010203, 0, 1, 1);
   endtask

   task automatic t_fade;
      cfg_mode = 3'd3;
      cfg_kp = 3'd2; cfg_ks = 3'd5; apply("R6 fade 2+5", 24'hFF8001, 0, 24'h40C0FF, 0, 2, 2);
      cfg_kp = 3'd4; cfg_ks = 3'd4; apply("R6 fade 4+4", 24'hFFFFFF, 0, 24'hFFFFFF, 0, 2, 2);
      cfg_kp = 3'd0; cfg_ks = 3'd0; apply("R6 fade 0+0", 24'hFFFFFF, 0, 24'hFFFFFF, 0, 2, 2);
   endtask

   task automatic t_key_primary;
      cfg_mode = 3'd5; cfg_key_range = 1'b1; cfg_key_prec = 3'd7;
      cfg_key_lo = 24'h102030; cfg_key_hi = 24'h405060;
      apply("R7 primary in range",     24'h203040, 0, 24'h0A0B0C, 0, 4, 4);
      apply("R7 primary at bounds",    24'h405030, 0, 24'h0A0B0C, 0, 4, 4);
      apply("R7 one channel outside",  24'h203061, 0, 24'h0A0B0C, 0, 4, 4);
   endtask

   task automatic t_precision;
      cfg_mode = 3'd5; cfg_key_range = 1'b1;
      cfg_key_lo = 24'h252525; cfg_key_hi = 24'h353535;
      cfg_key_prec = 3'd3; apply("R9 prec 3 coarse match",  24'h222222, 0, 24'h0A0B0C, 0, 5, 5);
      cfg_key_prec = 3'd7; apply("R9 prec 7 exact miss",    24'h222222, 0, 24'h0A0B0C, 0, 5, 5);
      cfg_key_lo = 24'h808080; cfg_key_hi = 24'hFFFFFF;
      cfg_key_prec = 3'd0; apply("R9 prec 0 top bit match", 24'h81C080, 0, 24'h0A0B0C, 0, 5, 5);
      apply("R9 prec 0 top bit miss",  24'h7FFFFF, 0, 24'h0A0B0C, 0, 5, 5);
   endtask

   task automatic t_key_secondary;
      cfg_mode = 3'd6; cfg_key_range = 1'b1; cfg_key_prec = 3'd7;
      cfg_key_lo = 24'h000000; cfg_key_hi = 24'h101010;
      apply("R8 secondary keyed",      24'h777777, 0, 24'h080808, 0, 6, 6);
      apply("R8 secondary not keyed",  24'h777777, 0, 24'h200808, 0, 6, 6);
   endtask

   task automatic t_key_flag;
      cfg_key_range = 1'b0;
      cfg_key_lo = 24'h000000; cfg_key_hi = 24'hFFFFFF;
      cfg_mode = 3'd5;
      apply("R10 primary flag set",    24'h123456, 1, 24'h654321, 0, 7, 7);
      apply("R10 flag clear in range", 24'h123456, 0, 24'h654321, 1, 7, 7);
      cfg_mode = 3'd6;
      apply("R10 secondary flag set",  24'h123456, 0, 24'h654321, 1, 7, 7);
      apply("R10 secondary flag clear", 24'h123456, 1, 24'h654321, 0, 7, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_window;
      t_opaque;
      t_dissolve;
      t_fade;
      t_key_primary;
      t_precision;
      t_key_secondary;
      t_key_flag;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule